// File: doc/BRIEF.md
# Successive Approximation Conversion Controller

This block sequences a successive-approximation analog-to-digital conversion. A falling edge on the trigger input starts a conversion. The trigger is first passed through a two-flop synchroniser. At that moment the block switches the sample/hold control to hold and clears its working state. It then decides one result bit per clock, beginning with the most significant bit. For each bit it presents a trial code to an external DAC and reads back a single comparator decision.

While a conversion runs, the busy flag stays high and any further trigger edges are ignored. At completion the result register is loaded, busy falls and a one-cycle done pulse is issued. The result is formatted as true binary, offset binary or two's complement, according to a coding select that is sampled when the conversion starts. It is read through a 16-bit port with separate high-byte and low-byte enables. Triggers that were high for fewer than a set number of clocks are flagged, because a sample/hold tied to the trigger would not have had time to acquire.

Top module: `sar_sequencer`

## Requirements
- R1: After `trig_in` falls, `busy` and `sh_hold` go high at the third rising clock edge. This delay covers two synchroniser flops plus the start register.
- R2: A trigger falling edge seen while `busy` is high does not start a conversion or change the one in progress. No extra `busy` period follows.
- R3: In the first busy cycle the trial register holds the active-low preset, with the MSB low and all others high. So `dac_code` equals only the MSB set (0x2000 for 14 bits).
- R4: One bit is decided per clock, MSB first. A bit is cleared when `cmp_in` is 1 (DAC above the input) and kept otherwise. `busy` stays high for exactly RES_W cycles, and the raw result equals the largest code whose DAC value does not exceed the input.
- R5: `busy` and `sh_hold` fall in the same cycle that `done` is high. `done` lasts exactly one cycle.
- R6: `code_sel` 2'b00 selects binary and 2'b01 offset binary; both give the raw result unchanged. 2'b10 selects two's complement, which is the raw result with its MSB inverted. 2'b11 acts as offset binary. The value is sampled only at conversion start, so a change during a conversion has no effect on its result.
- R7: The result register changes only at completion. A read during a conversion returns the previous result.
- R8: `data_bus[15:8]` carries the upper byte of the zero-extended result when `hi_en` is 1, and `data_bus[7:0]` the lower byte when `lo_en` is 1. A disabled byte reads as zero. `byte_valid` is {`hi_en`, `lo_en`}.
- R9: `short_trig` is set at the start of a conversion whose synchronised trigger was high for fewer than MIN_HIGH_CLKS clocks, and cleared at the next start otherwise.
- R10: After reset, `busy`, `done`, `sh_hold` and `short_trig` are 0, `dac_code` is 0, and the result reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_in | input | 1 | Asynchronous conversion trigger; falling edge starts |
| cmp_in | input | 1 | Comparator: 1 when the DAC output exceeds the input |
| code_sel | input | 2 | Output coding select |
| hi_en | input | 1 | High-byte read enable |
| lo_en | input | 1 | Low-byte read enable |
| dac_code | output | RES_W | Trial code to the DAC |
| sh_hold | output | 1 | Sample/hold control, 1 = hold |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion pulse |
| short_trig | output | 1 | Last accepted trigger was too short |
| data_bus | output | 16 | Byte-enabled result word |
| byte_valid | output | 2 | Which bytes of `data_bus` are driven |

## Verification
The bound checker watches every cycle for the following. The first busy cycle must present the MSB-only trial code, and hold must be entered at the start. Each busy period must last exactly RES_W cycles, done must coincide with busy falling and must never repeat. The bench's scenarios are needed for the rest: the numeric result for a given input level, the three codings, a coding change mid-conversion, the three-cycle start latency, the ignored retrigger, reads during a conversion, byte masking, and the short-trigger boundary at MIN_HIGH_CLKS.

// File: rtl/sar_pkg.sv
// Shared types for the successive-approximation sequencer.
package sar_pkg;
    // Output coding choices, decoded from the 2-bit select input.
    typedef enum logic [1:0] {
        CODE_BIN  = 2'b00,
        CODE_OFS  = 2'b01,
        CODE_TWOS = 2'b10,
        CODE_RSV  = 2'b11
    } code_e;
endpackage

// File: rtl/sar_trig_frontend.sv
// Trigger front end: synchronises the asynchronous trigger with two flops,
// detects its falling edge and measures how long it was high.
// Assumes trig_in is asynchronous to clk; pulse widths are in clk cycles.
module sar_trig_frontend #(
    parameter int MIN_HIGH_CLKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic fall_evt,
    output logic short_evt
);
    localparam int CNT_W = $clog2(MIN_HIGH_CLKS + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_HIGH_CLKS);

    logic sync1, sync2, sync3;
    logic [CNT_W-1:0] high_cnt;

    // Two-flop synchroniser plus one delay flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            sync3 <= 1'b0;
        end else begin
            sync1 <= trig_in;
            sync2 <= sync1;
            sync3 <= sync2;
        end
    end

    // Saturating count of cycles the synchronised trigger has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            high_cnt <= '0;
        else if (sync2) begin
            if (high_cnt != CNT_MAX)
                high_cnt <= high_cnt + 1'b1;
        end else
            high_cnt <= '0;
    end

    // Falling edge and short-pulse qualification.
    always_comb begin
        fall_evt  = sync3 && !sync2;
        short_evt = fall_evt && (high_cnt < CNT_MAX);
    end
endmodule

// File: rtl/sar_bit_engine.sv
// Bit engine: holds the active-low trial register and walks one bit per
// clock from MSB to LSB. A 0 in the register means the bit is switched on.
// Assumes cmp_in reflects dac_code within the same cycle.
module sar_bit_engine #(
    parameter int RES_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_in,
    output logic             busy,
    output logic             done,
    output logic             complete,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] final_code
);
    localparam int IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
    localparam logic [RES_W-1:0] PRESET_N = {1'b0, {(RES_W-1){1'b1}}};

    logic [RES_W-1:0] trial_n;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] idx_m1;

    // Next index and the last-step condition.
    always_comb begin
        idx_m1   = idx - 1'b1;
        complete = busy && (idx == '0);
    end

    // Sequencer: preset on start, then keep/clear and advance each clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trial_n <= '1;
            idx     <= '0;
            busy    <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    idx     <= IDX_W'(RES_W - 1);
                    trial_n <= PRESET_N;
                end
            end else begin
                if (cmp_in)
                    trial_n[idx] <= 1'b1;
                if (idx == '0) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    trial_n[idx_m1] <= 1'b0;
                    idx             <= idx_m1;
                end
            end
        end
    end

    // DAC code is the positive view; final code folds in the last decision.
    always_comb begin
        dac_code   = ~trial_n;
        final_code = {~trial_n[RES_W-1:1], ~cmp_in};
    end
endmodule

// File: rtl/sar_out_port.sv
// Output port: latches the coding select at start, loads the formatted
// result at completion and presents it through two byte enables.
// Assumes RES_W fits in the 16-bit bus.
module sar_out_port
    import sar_pkg::*;
#(
    parameter int RES_W = 14,
    parameter int BUS_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       code_sel,
    input  logic             complete,
    input  logic [RES_W-1:0] final_code,
    input  logic             hi_en,
    input  logic             lo_en,
    output logic [BUS_W-1:0] data_bus,
    output logic [1:0]       byte_valid
);
    localparam int NBYTES = BUS_W / 8;
    localparam logic [RES_W-1:0] MSB_MASK = {1'b1, {(RES_W-1){1'b0}}};

    code_e            code_q;
    logic [RES_W-1:0] result_q;
    logic [BUS_W-1:0] word;
    logic [NBYTES-1:0] byte_en;

    // Capture coding at start; load formatted result at completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q   <= CODE_BIN;
            result_q <= '0;
        end else begin
            if (start)
                code_q <= code_e'(code_sel);
            if (complete)
                result_q <= (code_q == CODE_TWOS) ? (final_code ^ MSB_MASK) : final_code;
        end
    end

    // Zero-extend the result and collect the byte enables, high byte first.
    always_comb begin
        word    = BUS_W'(result_q);
        byte_en = {hi_en, lo_en};
    end

    // One masked lane per byte.
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign data_bus[b*8 +: 8] = byte_en[b] ? word[b*8 +: 8] : 8'h00;
    end

    assign byte_valid = byte_en;
endmodule

// File: rtl/sar_sequencer.sv
// Top of the successive-approximation sequencer. Connects the trigger
// front end, bit engine and output port; owns the hold and short flags.
// Assumes RES_W is 14 or 15 and the analog parts sit outside.
module sar_sequencer #(
    parameter int RES_W         = 14,
    parameter int MIN_HIGH_CLKS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_in,
    input  logic             cmp_in,
    input  logic [1:0]       code_sel,
    input  logic             hi_en,
    input  logic             lo_en,
    output logic [RES_W-1:0] dac_code,
    output logic             sh_hold,
    output logic             busy,
    output logic             done,
    output logic             short_trig,
    output logic [15:0]      data_bus,
    output logic [1:0]       byte_valid
);
    logic             fall_evt, short_evt, accept, complete;
    logic [RES_W-1:0] final_code;

    sar_trig_frontend #(.MIN_HIGH_CLKS(MIN_HIGH_CLKS)) u_front (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
        .fall_evt(fall_evt), .short_evt(short_evt)
    );

    // A trigger edge counts only while idle.
    assign accept = fall_evt && !busy;

    sar_bit_engine #(.RES_W(RES_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .start(accept), .cmp_in(cmp_in),
        .busy(busy), .done(done), .complete(complete),
        .dac_code(dac_code), .final_code(final_code)
    );

    sar_out_port #(.RES_W(RES_W), .BUS_W(16)) u_port (
        .clk(clk), .rst_n(rst_n), .start(accept), .code_sel(code_sel),
        .complete(complete), .final_code(final_code),
        .hi_en(hi_en), .lo_en(lo_en),
        .data_bus(data_bus), .byte_valid(byte_valid)
    );

    // Hold from accepted start until the last decision; short flag per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hold    <= 1'b0;
            short_trig <= 1'b0;
        end else begin
            if (accept) begin
                sh_hold    <= 1'b1;
                short_trig <= short_evt;
            end else if (complete)
                sh_hold <= 1'b0;
        end
    end
endmodule

// File: rtl/sar_sequencer_chk.sv
// Checker for the sequencer: cycle-level rules on busy, done, hold and the
// first trial code. Attached to every sar_sequencer instance by bind.
module sar_sequencer_chk #(
    parameter int RES_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             done,
    input logic             sh_hold,
    input logic [RES_W-1:0] dac_code
);
    localparam logic [RES_W-1:0] MSB_ONLY = {1'b1, {(RES_W-1){1'b0}}};

    logic [7:0] busy_len;

    // Length of the current busy period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_len <= '0;
        else
            busy_len <= busy ? busy_len + 1'b1 : 8'd0;
    end

    // R3
    first_trial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> dac_code == MSB_ONLY);

    // R1
    hold_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> sh_hold);

    // R4
    busy_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len == 8'(RES_W));

    // R5
    done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($fell(busy) && !sh_hold));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind sar_sequencer sar_sequencer_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
    .sh_hold(sh_hold), .dac_code(dac_code)
);

// File: tb/sar_sequencer_test.sv
// Scoreboard bench: the driver queues expected words, the monitor pops
// them on every done pulse. A behavioural comparator closes the loop.
module sar_sequencer_test;
    localparam int RES_W = 14;
    localparam int MINH  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_in = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic hi_en = 1'b1, lo_en = 1'b1;
    logic [RES_W-1:0] dac_code;
    logic sh_hold, busy, done, short_trig, cmp_in;
    logic [15:0] data_bus;
    logic [1:0] byte_valid;
    int vin = 0;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [15:0] exp_q[$];
    logic [15:0] prev_word = 16'h0000;

    always #2.5 clk = ~clk;

    assign cmp_in = (int'(dac_code) > vin);

    sar_sequencer #(.RES_W(RES_W), .MIN_HIGH_CLKS(MINH)) uut (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .cmp_in(cmp_in),
        .code_sel(code_sel), .hi_en(hi_en), .lo_en(lo_en),
        .dac_code(dac_code), .sh_hold(sh_hold), .busy(busy), .done(done),
        .short_trig(short_trig), .data_bus(data_bus), .byte_valid(byte_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Expected word from the coding rules (R6).
    function automatic logic [15:0] fmt(input int v, input int code);
        logic [RES_W-1:0] r;
        r = RES_W'(v);
        if (code == 2) r[RES_W-1] = ~r[RES_W-1];
        return 16'(r);
    endfunction

    // Monitor: compare each completed result against the queue head.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0)
                check(0, "R2 unexpected result", int'(data_bus), 0);
            else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                check(data_bus == e, "R4/R6 result", int'(data_bus), int'(e));
            end
        end
    end

    // Driver: one conversion with optional mid-conversion disturbance.
    task automatic convert(input int v, input int code, input int hi_cyc,
                           input bit exp_short, input bit poke);
        int lat, bl;
        logic [15:0] e;
        vin = v;
        code_sel = 2'(code);
        e = fmt(v, code);
        exp_q.push_back(e);
        trig_in = 1'b1;
        repeat (hi_cyc) @(negedge clk);
        trig_in = 1'b0;
        lat = 0;
        do begin @(negedge clk); lat++; end while (!busy && lat < 20);
        check(lat == 3, "R1 start latency", lat, 3);
        check(sh_hold == 1'b1, "R1 hold at start", int'(sh_hold), 1);
        check(dac_code == RES_W'(1 << (RES_W-1)), "R3 first trial", int'(dac_code), 1 << (RES_W-1));
        check(short_trig == exp_short, "R9 short flag", int'(short_trig), int'(exp_short));
        bl = 1;
        forever begin
            @(negedge clk);
            if (!busy || bl > 40) break;
            bl++;
            if (poke) begin
                if (bl == 2) begin trig_in = 1'b1; code_sel = ~2'(code); end
                if (bl == 4) trig_in = 1'b0;
                if (bl == 6) check(data_bus == prev_word, "R7 read during conversion",
                                   int'(data_bus), int'(prev_word));
            end
        end
        check(bl == RES_W, "R4 busy length", bl, RES_W);
        check(done == 1'b1 && sh_hold == 1'b0, "R5 done at end", int'(done), 1);
        @(negedge clk);
        check(done == 1'b0, "R5 done one cycle", int'(done), 0);
        prev_word = e;
        if (poke) begin
            bit seen = 0;
            repeat (10) begin @(negedge clk); if (busy) seen = 1; end
            check(!seen, "R2 retrigger ignored", int'(seen), 0);
        end
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(busy == 0 && done == 0 && sh_hold == 0 && short_trig == 0, "R10 flags",
              int'({busy, done, sh_hold, short_trig}), 0);
        check(dac_code == '0, "R10 dac", int'(dac_code), 0);
        check(data_bus == 16'h0, "R10 result", int'(data_bus), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        convert(0,      0, 10, 0, 0);    // R4 zero
        convert(16383,  0, 10, 0, 0);    // R4 full scale
        convert(13'h1234, 1, 10, 0, 0);  // R6 offset binary
        convert(14'h2000, 2, 10, 0, 0);  // R6 two's complement midscale -> 0
        convert(14'h0005, 2, 10, 0, 0);  // R6 two's complement negative
        convert(14'h2AAA, 3, 10, 0, 0);  // R6 reserved acts as offset binary
        convert(MINH,   0, MINH, 0, 0);  // R9 boundary: exactly minimum
        convert(77,     0, MINH-1, 1, 0);// R9 one clock short
        convert(14'h1F0F, 2, 10, 0, 1);  // R2 retrigger, R6 late code change, R7
        convert(9999,   0, 12, 0, 0);    // R9 flag cleared again

        // R8 byte enables on the last result (9999 = 0x270F)
        hi_en = 1'b1; lo_en = 1'b0;
        @(negedge clk);
        check(data_bus == 16'h2700 && byte_valid == 2'b10, "R8 high byte only", int'(data_bus), 16'h2700);
        hi_en = 1'b0; lo_en = 1'b1;
        @(negedge clk);
        check(data_bus == 16'h000F && byte_valid == 2'b01, "R8 low byte only", int'(data_bus), 16'h000F);
        hi_en = 1'b0; lo_en = 1'b0;
        @(negedge clk);
        check(data_bus == 16'h0 && byte_valid == 2'b00, "R8 none", int'(data_bus), 0);
        hi_en = 1'b1; lo_en = 1'b1;
        @(negedge clk);
        check(data_bus == 16'h270F, "R8 both", int'(data_bus), 16'h270F);

        check(exp_q.size() == 0, "R4 results outstanding", exp_q.size(), 0);
        finish_run();
    end
endmodule